// File: doc/BRIEF.md
# Feistel Round Function Unit

This block computes the round function of a 64-bit Feistel cipher whose state is split into two 32-bit halves. In one clock cycle it takes one half, a 32-bit masking subkey and a 5-bit rotation subkey, and produces the 32-bit function value. It also produces that value already folded into the opposite half. A 2-bit select picks one of three round flavours. The flavours differ in how data and masking key are first combined and in the add/subtract/XOR chain that merges the four substitution-table words.

The substitution tables sit outside the block. The block presents four 8-bit indices at once, one per table. It expects the four 32-bit table words back in the same cycle, as a combinational ROM would give them. The table contents and the key schedule belong to the surrounding cipher. A round engine issues one round per cycle with `inValid` high and takes the registered result one cycle later.

Top module: `feistel_round_unit`

## Requirements
- R1: While `rstN` is low, and after its release until the first accepted input, `outValid` is 0 and `fOut` and `newHalf` are 0.
- R2: The pre-mix depends on `funcSel`. Code 2'b01, and also code 2'b00, uses `maskKey + dataHalf` mod 2^32. Code 2'b10 uses `maskKey ^ dataHalf`. Code 2'b11 uses `maskKey - dataHalf` mod 2^32.
- R3: The pre-mixed word is rotated left by `rotKey`, which is 0 to 31. An amount of 0 passes the pre-mixed word through unchanged.
- R4: The rotated word appears on `tblIdx` in the same cycle as the inputs. Bits [31:24] index table 1, [23:16] table 2, [15:8] table 3 and [7:0] table 4. The table words are read from `tblData`: [127:96] is table 1, [95:64] table 2, [63:32] table 3 and [31:0] table 4.
- R5: For codes 2'b00 and 2'b01 the function value is ((T1 ^ T2) - T3) + T4, mod 2^32.
- R6: For code 2'b10 the function value is ((T1 - T2) + T3) ^ T4, mod 2^32.
- R7: For code 2'b11 the function value is ((T1 + T2) ^ T3) - T4, mod 2^32.
- R8: `outValid` is high in exactly the cycle after a cycle with `inValid` high. `fOut` then holds the function value of that input cycle.
- R9: `newHalf` equals `otherHalf` of the accepted input cycle XORed with the function value of that cycle.
- R10: In a cycle with `inValid` low, `fOut` and `newHalf` keep their values in the next cycle, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Round inputs are valid this cycle |
| funcSel | input | 2 | Round flavour: 00/01 add, 10 xor, 11 subtract pre-mix |
| dataHalf | input | 32 | Half of the block fed to the round function |
| otherHalf | input | 32 | Half of the block that receives the function value |
| maskKey | input | 32 | Masking subkey |
| rotKey | input | 5 | Left-rotation amount |
| tblIdx | output | 32 | Four packed 8-bit table indices, table 1 in the top byte |
| tblData | input | 128 | Four packed 32-bit table words, table 1 in the top word |
| outValid | output | 1 | Registered result is fresh |
| fOut | output | 32 | Registered round-function value |
| newHalf | output | 32 | Registered `otherHalf` XOR function value |

## Verification
The output register can capture one round's result in the same cycle that the lookup ports already carry the indices of the next round. The bench provokes this by holding `inValid` high across back-to-back vectors. In every cycle it compares `tblIdx` with the index expected for the current inputs, and `fOut`/`newHalf` with the result expected for the previous cycle. The sweep covers every `funcSel` code, every rotation amount and pre-mix operands chosen to wrap, underflow and saturate. A separate window with `inValid` low and churning inputs shows that the hold path does not interfere with the lookup path.

// File: rtl/feistel_rf_pkg.sv
package feistel_rf_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_XOR = 2'd1,
    OP_SUB = 2'd2
  } opKind_e;

  typedef struct packed {
    opKind_e premixOp;
    opKind_e mix1Op;
    opKind_e mix2Op;
    opKind_e mix3Op;
    logic    capture;
  } rfStrobe_t;

endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import feistel_rf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] funcSel,
  output rfStrobe_t  strobe,
  output logic       outValid
);

  // Flavour decode: each flavour shifts the op pattern by one place.
  always_comb begin
    strobe.capture = inValid;
    unique case (funcSel)
      2'b10: begin
        strobe.premixOp = OP_XOR;
        strobe.mix1Op   = OP_SUB;
        strobe.mix2Op   = OP_ADD;
        strobe.mix3Op   = OP_XOR;
      end
      2'b11: begin
        strobe.premixOp = OP_SUB;
        strobe.mix1Op   = OP_ADD;
        strobe.mix2Op   = OP_XOR;
        strobe.mix3Op   = OP_SUB;
      end
      default: begin
        strobe.premixOp = OP_ADD;
        strobe.mix1Op   = OP_XOR;
        strobe.mix2Op   = OP_SUB;
        strobe.mix3Op   = OP_ADD;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import feistel_rf_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rfStrobe_t                     strobe,
  input  logic [HALF_W-1:0]             dataHalf,
  input  logic [HALF_W-1:0]             otherHalf,
  input  logic [HALF_W-1:0]             maskKey,
  input  logic [$clog2(HALF_W)-1:0]     rotAmt,
  output logic [HALF_W-1:0]             tblIdx,
  input  logic [HALF_W*(HALF_W/IDX_W)-1:0] tblData,
  output logic [HALF_W-1:0]             fOut,
  output logic [HALF_W-1:0]             newHalf
);

  localparam int ROT_W   = $clog2(HALF_W);
  localparam int NUM_TBL = HALF_W / IDX_W;

  function automatic logic [HALF_W-1:0] applyOp(
    input opKind_e op,
    input logic [HALF_W-1:0] a,
    input logic [HALF_W-1:0] b
  );
    unique case (op)
      OP_XOR:  return a ^ b;
      OP_SUB:  return a - b;
      default: return a + b;
    endcase
  endfunction

  // Pre-mix: key is the left operand so subtract gives key minus data.
  logic [HALF_W-1:0] premixVal;
  assign premixVal = applyOp(strobe.premixOp, maskKey, dataHalf);

  // Logarithmic left rotator.
  logic [HALF_W-1:0] rotStage [ROT_W+1];
  assign rotStage[0] = premixVal;

  for (genvar s = 0; s < ROT_W; s++) begin : g_rot
    localparam int SH = 1 << s;
    assign rotStage[s+1] = rotAmt[s]
      ? {rotStage[s][HALF_W-1-SH:0], rotStage[s][HALF_W-1:HALF_W-SH]}
      : rotStage[s];
  end

  // Byte split and table word unpack; slot 0 is the top byte / top word.
  logic [HALF_W-1:0] tblWord [NUM_TBL];

  for (genvar k = 0; k < NUM_TBL; k++) begin : g_slot
    assign tblIdx[HALF_W-1-k*IDX_W -: IDX_W] =
      rotStage[ROT_W][HALF_W-1-k*IDX_W -: IDX_W];
    assign tblWord[k] = tblData[HALF_W*(NUM_TBL-k)-1 -: HALF_W];
  end

  // Three-step merge chain.
  logic [HALF_W-1:0] mixA, mixB, fNext;
  assign mixA  = applyOp(strobe.mix1Op, tblWord[0], tblWord[1]);
  assign mixB  = applyOp(strobe.mix2Op, mixA, tblWord[2]);
  assign fNext = applyOp(strobe.mix3Op, mixB, tblWord[NUM_TBL-1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fOut    <= '0;
      newHalf <= '0;
    end else if (strobe.capture) begin
      fOut    <= fNext;
      newHalf <= otherHalf ^ fNext;
    end
  end

endmodule

// File: rtl/feistel_round_unit.sv
module feistel_round_unit
  import feistel_rf_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [1:0]                  funcSel,
  input  logic [HALF_W-1:0]           dataHalf,
  input  logic [HALF_W-1:0]           otherHalf,
  input  logic [HALF_W-1:0]           maskKey,
  input  logic [$clog2(HALF_W)-1:0]   rotKey,
  output logic [HALF_W-1:0]           tblIdx,
  input  logic [HALF_W*(HALF_W/8)-1:0] tblData,
  output logic                        outValid,
  output logic [HALF_W-1:0]           fOut,
  output logic [HALF_W-1:0]           newHalf
);

  rfStrobe_t strobe;

  rf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .funcSel  (funcSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  rf_datapath #(
    .HALF_W (HALF_W),
    .IDX_W  (8)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dataHalf  (dataHalf),
    .otherHalf (otherHalf),
    .maskKey   (maskKey),
    .rotAmt    (rotKey),
    .tblIdx    (tblIdx),
    .tblData   (tblData),
    .fOut      (fOut),
    .newHalf   (newHalf)
  );

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int HALF_W = 32
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      inValid,
  input logic [1:0]                funcSel,
  input logic [HALF_W-1:0]         dataHalf,
  input logic [HALF_W-1:0]         otherHalf,
  input logic [HALF_W-1:0]         maskKey,
  input logic [$clog2(HALF_W)-1:0] rotKey,
  input logic [HALF_W-1:0]         tblIdx,
  input logic                      outValid,
  input logic [HALF_W-1:0]         fOut,
  input logic [HALF_W-1:0]         newHalf
);

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(fOut) && $stable(newHalf)));

  p_fold_other_half_r9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (newHalf == ($past(otherHalf) ^ fOut)));

  p_rot_zero_passthru_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rotKey == '0 && funcSel == 2'b10) |-> (tblIdx == (dataHalf ^ maskKey)));

endmodule

bind feistel_round_unit rf_checker #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .funcSel   (funcSel),
  .dataHalf  (dataHalf),
  .otherHalf (otherHalf),
  .maskKey   (maskKey),
  .rotKey    (rotKey),
  .tblIdx    (tblIdx),
  .outValid  (outValid),
  .fOut      (fOut),
  .newHalf   (newHalf)
);

// File: tb/sim_feistel_round_unit.sv
`timescale 1ns/1ps
module sim_feistel_round_unit;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   funcSel = '0;
  logic [31:0]  dataHalf = '0, otherHalf = '0, maskKey = '0;
  logic [4:0]   rotKey = '0;
  logic [31:0]  tblIdx;
  logic [127:0] tblData;
  logic         outValid;
  logic [31:0]  fOut, newHalf;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  feistel_round_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .funcSel(funcSel),
    .dataHalf(dataHalf), .otherHalf(otherHalf), .maskKey(maskKey),
    .rotKey(rotKey), .tblIdx(tblIdx), .tblData(tblData),
    .outValid(outValid), .fOut(fOut), .newHalf(newHalf)
  );

  // Arithmetic stand-in tables, k = 0 is table 1.
  function automatic logic [31:0] tblFunc(input int k, input logic [7:0] idx);
    logic [31:0] v;
    v = {idx, idx ^ 8'hA5, idx + 8'(k * 37 + 11), ~idx};
    v = v * 32'h9E3779B1 + 32'(k);
    return v ^ (v >> 13);
  endfunction

  always_comb begin
    for (int k = 0; k < 4; k++)
      tblData[127 - 32*k -: 32] = tblFunc(k, tblIdx[31 - 8*k -: 8]);
  end

  function automatic logic [31:0] refIdx(input logic [1:0] sel, input logic [31:0] d,
                                         input logic [31:0] key, input logic [4:0] r);
    logic [31:0] pm;
    logic [63:0] dbl;
    case (sel)
      2'b10:   pm = key ^ d;
      2'b11:   pm = key - d;
      default: pm = key + d;
    endcase
    dbl = {pm, pm} << r;
    return dbl[63:32];
  endfunction

  function automatic logic [31:0] refF(input logic [1:0] sel, input logic [31:0] idx);
    logic [31:0] t1, t2, t3, t4;
    t1 = tblFunc(0, idx[31:24]);
    t2 = tblFunc(1, idx[23:16]);
    t3 = tblFunc(2, idx[15:8]);
    t4 = tblFunc(3, idx[7:0]);
    case (sel)
      2'b10:   return ((t1 - t2) + t3) ^ t4;
      2'b11:   return ((t1 + t2) ^ t3) - t4;
      default: return ((t1 ^ t2) - t3) + t4;
    endcase
  endfunction

  function automatic string selTag(input logic [1:0] sel);
    case (sel)
      2'b10:   return "R2/R6";
      2'b11:   return "R2/R7";
      default: return "R2/R5";
    endcase
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic patternOf(input int p, output logic [31:0] d, output logic [31:0] key);
    case (p)
      0: begin d = 32'h0;        key = 32'h0;        end
      1: begin d = 32'hFFFFFFFF; key = 32'hFFFFFFFF; end
      2: begin d = 32'hFFFFFFFF; key = 32'h00000001; end
      3: begin d = 32'h00000001; key = 32'h00000000; end
      default: begin
        d   = 32'h01234567 * 32'(p) ^ 32'hC3A5_0F1E;
        key = 32'h89ABCDEF + 32'(p * 7919);
      end
    endcase
  endtask

  logic [31:0] expF, expNew;

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, key, oth, idx;
    // R1: reset state
    repeat (3) @(negedge clk);
    check32("R1 outValid in reset", {31'b0, outValid}, 32'h0);
    check32("R1 fOut in reset", fOut, 32'h0);
    check32("R1 newHalf in reset", newHalf, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check32("R1 outValid after release", {31'b0, outValid}, 32'h0);
    check32("R1 fOut after release", fOut, 32'h0);

    // Back-to-back sweep: every code, every rotation, eight operand patterns.
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 8; p++) begin
        for (int r = 0; r < 32; r++) begin
          patternOf(p, d, key);
          oth = d ^ 32'h5A5A_0000 ^ 32'(r * 977);
          funcSel   = 2'(s);
          dataHalf  = d;
          maskKey   = key;
          otherHalf = oth;
          rotKey    = 5'(r);
          inValid   = 1'b1;
          #1;
          idx = refIdx(2'(s), d, key, 5'(r));
          check32("R3/R4 tblIdx", tblIdx, idx);
          expF   = refF(2'(s), idx);
          expNew = oth ^ expF;
          @(negedge clk);
          check32("R8 outValid", {31'b0, outValid}, 32'h1);
          check32(selTag(2'(s)), fOut, expF);
          check32("R9 newHalf", newHalf, expNew);
        end
      end
    end

    // R10: idle window with churning inputs.
    inValid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      dataHalf  = 32'hDEAD0000 + 32'(i);
      maskKey   = 32'h1234 * 32'(i + 1);
      otherHalf = ~dataHalf;
      funcSel   = 2'(i);
      rotKey    = 5'(i * 5);
      @(negedge clk);
      check32("R10 fOut hold", fOut, expF);
      check32("R10 newHalf hold", newHalf, expNew);
      check32("R8 outValid low when idle", {31'b0, outValid}, 32'h0);
    end

    // R3: zero rotation passes the pre-mix through.
    funcSel = 2'b11; dataHalf = 32'h00000005; maskKey = 32'h00000003; rotKey = 5'd0;
    #1;
    check32("R3 zero rotation", tblIdx, 32'hFFFFFFFE);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule